// File: doc/BRIEF.md
# Bus Access Protection Checker

This block sits between the bus masters and a single memory target, for example an on-chip SRAM. Every request reaches it with the master ID that the interconnect attached in hardware, an address, a read/write flag, and security and privilege attributes. In the same cycle the block compares the request against a table of programmable rules. Each rule ties one master ID to an inclusive address window, a set of allowed operations and optional attribute demands. A request that some rule grants is passed straight through to the target. Any other request never reaches the target: one cycle after it is accepted, an error response with the requester's ID is returned.

Only one master ID, fixed by a parameter, may read or write the rule table and the fault control register through a small register port. That trusted master's own data accesses are always forwarded. The first rejected data access is captured as a fault record. A sticky flag marks it, and an overflow bit notes any later rejections until the trusted master clears the flag.

Top module: `bus_guard`

## Requirements
- R1: After reset every rule reads back with a control word of 0 (invalid), the fault flag and the overflow bit are 0, and every data request from a master other than the trusted one is blocked.
- R2: A request is forwarded (tgt_valid high in the same cycle, no error response next cycle) when a valid rule has the same master ID, start <= address <= end with both bounds inclusive, and enables the requested operation. An address one below the start or one above the end, or a different master ID, is blocked.
- R3: For a rule with read enabled and write disabled, a read in its window is forwarded and a write in its window is blocked.
- R4: A blocked request is never presented to the target (tgt_valid stays low). In the next cycle err_valid is 1 and err_id holds the requester's ID.
- R5: A rule whose need-secure bit is set grants only requests with req_secure=1. A rule whose need-privileged bit is set grants only requests with req_priv=1.
- R6: The register port is decoded as follows. cfg_addr[5]=0 selects rule cfg_addr[4:2]. Field cfg_addr[1:0] is 0 for control, 1 for start address and 2 for end address. The control word holds bit0 valid, bit1 read-enable, bit2 write-enable, bit3 need-secure, bit4 need-privileged, and bits 12:8 master ID. Writes from the trusted ID take effect. A write or read from any other ID changes nothing, reads back 0, and sets cfg_err in the next cycle.
- R7: The first blocked data request sets the fault flag and records its master ID, address and write flag. The record and the flag stay unchanged through later blocked requests.
- R8: A blocked request while the fault flag is set raises the overflow bit. Reading cfg_addr[5]=1 gives bit0 flag and bit1 overflow. A trusted write there with data bit0=1 clears both.
- R9: When several rules match a request, it is forwarded if any one of them grants the requested operation.
- R10: Data requests from the trusted master ID are always forwarded, whatever the table holds.
- R11: When a clear of the fault flag and a blocked request fall in the same cycle, the blocked request is recorded, the flag stays 1 and the overflow bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Data request present |
| req_id | input | 5 | Master ID of the request |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Request is secure |
| req_priv | input | 1 | Request is privileged |
| tgt_valid | output | 1 | Request forwarded to target |
| tgt_addr | output | 32 | Address to target |
| tgt_write | output | 1 | Write flag to target |
| tgt_wdata | output | 32 | Write data to target |
| err_valid | output | 1 | Error response for the previous-cycle request |
| err_id | output | 5 | Master ID the error response is addressed to |
| cfg_valid | input | 1 | Register access present |
| cfg_id | input | 5 | Master ID of the register access |
| cfg_write | input | 1 | 1 = register write |
| cfg_addr | input | 6 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| cfg_err | output | 1 | Register access refused in the previous cycle |
| fault_flag | output | 1 | Sticky first-fault flag |
| fault_ovf | output | 1 | More faults arrived after the first |
| fault_id | output | 5 | Recorded master ID |
| fault_addr | output | 32 | Recorded address |
| fault_write | output | 1 | Recorded write flag |

## Verification
The fault logger can receive a clear from the trusted master and a fresh violation on the data port in the same clock. The bench forces this collision by driving a trusted clear to the fault control register on the register port in the same cycle as a blocked data request. One cycle later it expects the flag still set, the overflow bit zero and the record holding the new request's ID and address. Before that, an earlier violation is left pending so that a design that lets the clear win, or that treats the new fault as an overflow, gives a visibly different result.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int ID_W   = 5;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CFG_AW = 6;
    localparam int CTRL_ID_LSB = 8;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic              rd_en;
        logic              wr_en;
        logic              need_sec;
        logic              need_priv;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } rule_t;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              secure;
        logic              priv;
    } xact_t;

    typedef enum logic [1:0] {
        FLD_CTRL = 2'd0,
        FLD_LO   = 2'd1,
        FLD_HI   = 2'd2,
        FLD_RSV  = 2'd3
    } field_e;

    function automatic logic [DATA_W-1:0] pack_ctrl(rule_t r);
        logic [DATA_W-1:0] d;
        d = '0;
        d[0] = r.valid;
        d[1] = r.rd_en;
        d[2] = r.wr_en;
        d[3] = r.need_sec;
        d[4] = r.need_priv;
        d[CTRL_ID_LSB +: ID_W] = r.id;
        return d;
    endfunction

    function automatic rule_t apply_ctrl(rule_t r, logic [DATA_W-1:0] d);
        rule_t n;
        n = r;
        n.valid     = d[0];
        n.rd_en     = d[1];
        n.wr_en     = d[2];
        n.need_sec  = d[3];
        n.need_priv = d[4];
        n.id        = d[CTRL_ID_LSB +: ID_W];
        return n;
    endfunction

    function automatic logic rule_grants(rule_t r, xact_t x);
        logic in_win, op_ok, attr_ok;
        in_win  = (x.addr >= r.lo) && (x.addr <= r.hi);
        op_ok   = x.write ? r.wr_en : r.rd_en;
        attr_ok = (!r.need_sec || x.secure) && (!r.need_priv || x.priv);
        return r.valid && (r.id == x.id) && in_win && op_ok && attr_ok;
    endfunction
endpackage

// File: rtl/guard_rule_table.sv
module guard_rule_table
    import guard_pkg::*;
#(
    parameter int N_RULES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CFG_AW-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output rule_t [N_RULES-1:0]   rules,
    output logic [DATA_W-1:0]     rdata
);
    localparam int SEL_W = CFG_AW - 3;

    logic [SEL_W-1:0] sel;
    field_e           fld;

    assign sel = addr[CFG_AW-2:2];
    assign fld = field_e'(addr[1:0]);

    for (genvar k = 0; k < N_RULES; k++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                rules[k] <= '0;
            end else if (wr_en && !addr[CFG_AW-1] && int'(sel) == k) begin
                case (fld)
                    FLD_CTRL: rules[k] <= apply_ctrl(rules[k], wdata);
                    FLD_LO:   rules[k].lo <= wdata[ADDR_W-1:0];
                    FLD_HI:   rules[k].hi <= wdata[ADDR_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < N_RULES; k++) begin
            if (int'(sel) == k) begin
                case (fld)
                    FLD_CTRL: rdata = pack_ctrl(rules[k]);
                    FLD_LO:   rdata = rules[k].lo;
                    FLD_HI:   rdata = rules[k].hi;
                    default:  rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/guard_match.sv
module guard_match
    import guard_pkg::*;
#(
    parameter int N_RULES = 8
) (
    input  rule_t [N_RULES-1:0] rules,
    input  xact_t               xact,
    output logic                granted
);
    logic [N_RULES-1:0] hit;

    for (genvar k = 0; k < N_RULES; k++) begin : g_cmp
        assign hit[k] = rule_grants(rules[k], xact);
    end

    assign granted = |hit;
endmodule

// File: rtl/guard_fault_log.sv
module guard_fault_log
    import guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              viol,
    input  xact_t             xact,
    input  logic              clr,
    output logic              flag,
    output logic              ovf,
    output logic [ID_W-1:0]   rec_id,
    output logic [ADDR_W-1:0] rec_addr,
    output logic              rec_write
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag      <= 1'b0;
            ovf       <= 1'b0;
            rec_id    <= '0;
            rec_addr  <= '0;
            rec_write <= 1'b0;
        end else if (viol) begin
            if (!flag || clr) begin
                flag      <= 1'b1;
                ovf       <= 1'b0;
                rec_id    <= xact.id;
                rec_addr  <= xact.addr;
                rec_write <= xact.write;
            end else begin
                ovf <= 1'b1;
            end
        end else if (clr) begin
            flag <= 1'b0;
            ovf  <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_guard.sv
module bus_guard
    import guard_pkg::*;
#(
    parameter int              N_RULES    = 8,
    parameter logic [ID_W-1:0] TRUSTED_ID = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_secure,
    input  logic              req_priv,
    output logic              tgt_valid,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              tgt_write,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic              err_valid,
    output logic [ID_W-1:0]   err_id,
    input  logic              cfg_valid,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              cfg_err,
    output logic              fault_flag,
    output logic              fault_ovf,
    output logic [ID_W-1:0]   fault_id,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              fault_write
);
    xact_t               xact;
    rule_t [N_RULES-1:0] rules;
    logic [DATA_W-1:0]   rule_rdata;
    logic                granted, allow, blocked;
    logic                cfg_ok, tbl_wr, fault_clr;

    assign xact = '{id: req_id, addr: req_addr, write: req_write,
                    secure: req_secure, priv: req_priv};

    assign cfg_ok    = cfg_valid && (cfg_id == TRUSTED_ID);
    assign tbl_wr    = cfg_ok && cfg_write;
    assign fault_clr = tbl_wr && cfg_addr[CFG_AW-1] && cfg_wdata[0];

    guard_rule_table #(.N_RULES(N_RULES)) u_table (
        .clk   (clk),
        .rst   (rst),
        .wr_en (tbl_wr),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rules (rules),
        .rdata (rule_rdata)
    );

    guard_match #(.N_RULES(N_RULES)) u_match (
        .rules   (rules),
        .xact    (xact),
        .granted (granted)
    );

    assign allow   = granted || (req_id == TRUSTED_ID);
    assign blocked = req_valid && !allow;

    assign tgt_valid = req_valid && allow;
    assign tgt_addr  = req_addr;
    assign tgt_write = req_write;
    assign tgt_wdata = req_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_id    <= '0;
            cfg_err   <= 1'b0;
        end else begin
            err_valid <= blocked;
            err_id    <= req_id;
            cfg_err   <= cfg_valid && !cfg_ok;
        end
    end

    guard_fault_log u_fault (
        .clk       (clk),
        .rst       (rst),
        .viol      (blocked),
        .xact      (xact),
        .clr       (fault_clr),
        .flag      (fault_flag),
        .ovf       (fault_ovf),
        .rec_id    (fault_id),
        .rec_addr  (fault_addr),
        .rec_write (fault_write)
    );

    always_comb begin
        cfg_rdata = '0;
        if (cfg_id == TRUSTED_ID) begin
            if (cfg_addr[CFG_AW-1])
                cfg_rdata = {{(DATA_W-2){1'b0}}, fault_ovf, fault_flag};
            else
                cfg_rdata = rule_rdata;
        end
    end
endmodule

// File: rtl/bus_guard_chk.sv
module bus_guard_chk
    import guard_pkg::*;
#(
    parameter logic [ID_W-1:0] TRUSTED_ID = '0
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [ID_W-1:0] req_id,
    input logic            tgt_valid,
    input logic            err_valid,
    input logic            cfg_valid,
    input logic [ID_W-1:0] cfg_id,
    input logic            cfg_err,
    input logic            fault_flag,
    input logic            fault_ovf
);
    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (!fault_flag && !fault_ovf && !err_valid));

    // R4
    block_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !tgt_valid) |=> err_valid);

    // R2
    pass_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |=> !err_valid);

    // R10
    trusted_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_id == TRUSTED_ID) |-> tgt_valid);

    // R6
    cfg_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_id != TRUSTED_ID) |=> cfg_err);

    // R7
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_flag) |-> $past(req_valid && !tgt_valid));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_ovf) |-> $past(fault_flag));
endmodule

bind bus_guard bus_guard_chk #(.TRUSTED_ID(TRUSTED_ID)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_id     (req_id),
    .tgt_valid  (tgt_valid),
    .err_valid  (err_valid),
    .cfg_valid  (cfg_valid),
    .cfg_id     (cfg_id),
    .cfg_err    (cfg_err),
    .fault_flag (fault_flag),
    .fault_ovf  (fault_ovf)
);

// File: tb/bus_guard_test.sv
`timescale 1ns/1ps
module bus_guard_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_write = 0, req_secure = 0, req_priv = 0;
    logic [4:0]  req_id = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic        tgt_valid, tgt_write, err_valid, cfg_err;
    logic [31:0] tgt_addr, tgt_wdata, cfg_rdata, fault_addr;
    logic [4:0]  err_id, fault_id;
    logic        cfg_valid = 0, cfg_write = 0;
    logic [4:0]  cfg_id = 0;
    logic [5:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic        fault_flag, fault_ovf, fault_write;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bus_guard uut (.*);

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic access(input logic [4:0] id, input logic [31:0] a,
                          input logic wr, input logic sec, input logic pv,
                          output logic fwd, output logic err, output logic [4:0] eid);
        @(negedge clk);
        req_valid = 1; req_id = id; req_addr = a; req_write = wr;
        req_wdata = a ^ 32'h5A5A_0000; req_secure = sec; req_priv = pv;
        #1 fwd = tgt_valid;
        @(negedge clk);
        err = err_valid; eid = err_id;
        req_valid = 0;
    endtask

    task automatic expect_access(string rq, input logic [4:0] id, input logic [31:0] a,
                                 input logic wr, input logic sec, input logic pv,
                                 input logic pass);
        logic f, e; logic [4:0] ei;
        access(id, a, wr, sec, pv, f, e, ei);
        check(rq, {31'b0, f}, {31'b0, pass});
        check(rq, {31'b0, e}, {31'b0, !pass});
    endtask

    task automatic cfg_wr(input logic [4:0] id, input logic [5:0] a,
                          input logic [31:0] d, output logic ce);
        @(negedge clk);
        cfg_valid = 1; cfg_id = id; cfg_write = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        ce = cfg_err;
        cfg_valid = 0; cfg_write = 0;
    endtask

    task automatic cfg_rd(input logic [4:0] id, input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_valid = 1; cfg_id = id; cfg_write = 0; cfg_addr = a;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_valid = 0;
    endtask

    task automatic clear_fault();
        logic ce;
        cfg_wr(5'd0, 6'h20, 32'h1, ce);
    endtask

    task automatic program_rule(input int k, input logic [31:0] ctrl,
                                input logic [31:0] lo, input logic [31:0] hi);
        logic ce;
        cfg_wr(5'd0, 6'(k * 4 + 1), lo, ce);
        cfg_wr(5'd0, 6'(k * 4 + 2), hi, ce);
        cfg_wr(5'd0, 6'(k * 4), ctrl, ce);
    endtask

    task automatic test_reset();
        logic [31:0] d; logic f, e; logic [4:0] ei;
        check("R1 flag", {31'b0, fault_flag}, 32'h0);
        check("R1 ovf", {31'b0, fault_ovf}, 32'h0);
        cfg_rd(5'd0, 6'h00, d);  check("R1 rule0 ctrl", d, 32'h0);
        cfg_rd(5'd0, 6'h1C, d);  check("R1 rule7 ctrl", d, 32'h0);
        access(5'd5, 32'h2000_0000, 1'b0, 1'b1, 1'b1, f, e, ei);
        check("R1 blocked fwd", {31'b0, f}, 32'h0);
        check("R4 err_valid", {31'b0, e}, 32'h1);
        check("R4 err_id", {27'b0, ei}, 32'd5);
        check("R7 flag set", {31'b0, fault_flag}, 32'h1);
        check("R7 rec id", {27'b0, fault_id}, 32'd5);
        check("R7 rec addr", fault_addr, 32'h2000_0000);
        check("R7 rec write", {31'b0, fault_write}, 32'h0);
    endtask

    task automatic test_trusted();
        expect_access("R10 trusted write", 5'd0, 32'h9000_0000, 1'b1, 1'b0, 1'b0, 1'b1);
        expect_access("R10 trusted read", 5'd0, 32'h0000_0010, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R10 no ovf", {31'b0, fault_ovf}, 32'h0);
    endtask

    task automatic test_first_ovf();
        logic [31:0] d;
        expect_access("R8 second fault", 5'd6, 32'h0000_1234, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 ovf set", {31'b0, fault_ovf}, 32'h1);
        check("R7 rec kept", {27'b0, fault_id}, 32'd5);
        cfg_rd(5'd0, 6'h20, d);  check("R8 status read", d, 32'h3);
        clear_fault();
        cfg_rd(5'd0, 6'h20, d);  check("R8 cleared", d, 32'h0);
    endtask

    task automatic setup_rules();
        logic [31:0] d;
        program_rule(0, 32'h0C07, 32'h2000_0000, 32'h2001_FFFF);
        program_rule(1, 32'h0103, 32'h2000_0000, 32'h2000_1FFF);
        program_rule(2, 32'h031F, 32'h3000_0000, 32'h3000_00FF);
        program_rule(3, 32'h0703, 32'h4000_0000, 32'h4000_0FFF);
        program_rule(4, 32'h0705, 32'h4000_0800, 32'h4000_0FFF);
        cfg_rd(5'd0, 6'h00, d);  check("R6 ctrl readback", d, 32'h0C07);
        cfg_rd(5'd0, 6'h01, d);  check("R6 lo readback", d, 32'h2000_0000);
        cfg_rd(5'd0, 6'h0A, d);  check("R6 hi readback", d, 32'h3000_00FF);
    endtask

    task automatic test_window();
        expect_access("R2 at start", 5'd12, 32'h2000_0000, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_access("R2 at end", 5'd12, 32'h2001_FFFF, 1'b1, 1'b0, 1'b0, 1'b1);
        expect_access("R2 end+1", 5'd12, 32'h2002_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_access("R2 start-1", 5'd12, 32'h1FFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_access("R2 other id", 5'd13, 32'h2000_0100, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_readonly();
        expect_access("R3 read ok", 5'd1, 32'h2000_1000, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_access("R3 write denied", 5'd1, 32'h2000_1000, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_attr();
        expect_access("R5 sec priv ok", 5'd3, 32'h3000_0010, 1'b1, 1'b1, 1'b1, 1'b1);
        expect_access("R5 nonsecure", 5'd3, 32'h3000_0010, 1'b1, 1'b0, 1'b1, 1'b0);
        expect_access("R5 unpriv", 5'd3, 32'h3000_0010, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_overlap();
        expect_access("R9 write via 2nd rule", 5'd7, 32'h4000_0900, 1'b1, 1'b0, 1'b0, 1'b1);
        expect_access("R9 write outside", 5'd7, 32'h4000_0100, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_access("R9 read via 1st rule", 5'd7, 32'h4000_0900, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic test_cfg_guard();
        logic ce; logic [31:0] d;
        cfg_wr(5'd12, 6'h00, 32'h0, ce);
        check("R6 untrusted err", {31'b0, ce}, 32'h1);
        cfg_rd(5'd0, 6'h00, d);  check("R6 ctrl unchanged", d, 32'h0C07);
        cfg_rd(5'd12, 6'h00, d); check("R6 untrusted read zero", d, 32'h0);
        cfg_wr(5'd0, 6'h0D, 32'h4000_0000, ce);
        check("R6 trusted no err", {31'b0, ce}, 32'h0);
        expect_access("R6 rule still live", 5'd12, 32'h2000_0040, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic test_fault();
        clear_fault();
        expect_access("R7 fault A", 5'd13, 32'h5000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R7 flag", {31'b0, fault_flag}, 32'h1);
        check("R7 id", {27'b0, fault_id}, 32'd13);
        check("R7 write", {31'b0, fault_write}, 32'h1);
        check("R8 no ovf yet", {31'b0, fault_ovf}, 32'h0);
        expect_access("R8 fault B", 5'd14, 32'h5000_0100, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 ovf", {31'b0, fault_ovf}, 32'h1);
        check("R7 addr kept", fault_addr, 32'h5000_0000);
    endtask

    task automatic test_same_cycle();
        @(negedge clk);
        cfg_valid = 1; cfg_id = 5'd0; cfg_write = 1; cfg_addr = 6'h20; cfg_wdata = 32'h1;
        req_valid = 1; req_id = 5'd9; req_addr = 32'h6000_0004; req_write = 0;
        req_secure = 0; req_priv = 0;
        @(negedge clk);
        cfg_valid = 0; cfg_write = 0; req_valid = 0;
        check("R11 flag kept", {31'b0, fault_flag}, 32'h1);
        check("R11 ovf cleared", {31'b0, fault_ovf}, 32'h0);
        check("R11 new id", {27'b0, fault_id}, 32'd9);
        check("R11 new addr", fault_addr, 32'h6000_0004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        test_reset();
        test_trusted();
        test_first_ovf();
        setup_rules();
        test_window();
        test_readonly();
        test_attr();
        test_overlap();
        test_cfg_guard();
        test_fault();
        test_same_cycle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule